// File: doc/BRIEF.md
# Privileged Map Context Controller

This block holds the page-map context that a small processor is currently running in, and it enforces privilege from that context. The processor has eight map contexts, chosen by a 3-bit index. The lower half of the index space (0 to 3) is supervisor space. The upper half (4 to 7) is user space. No separate mode bit exists: the supervisor flag is simply the inverse of the index's top bit. A second 3-bit index is kept for DMA transfers. It sits beside the processor's index but is written and read on its own.

The instruction decoder tells the block when a privileged instruction is issued. It also raises a strobe for a supervisor call and may write either index. If a privileged instruction is issued in user space, the block raises a one-cycle abort and freezes the active index for that cycle. A supervisor call forces the active index to context 0 and asks for a program-counter redirect to the system-call entry at 0x0100. Every input is a plain per-cycle control strobe. No data stream crosses the block's edge, so there is no valid/ready handshake and no back-pressure.

Top module: `map_ctx_ctrl`

## Requirements
- R1: After reset, active_map and dma_map are 0, supervisor is 1, and abort and redirect_valid are 0.
- R2: supervisor is 1 exactly when bit 2 of active_map is 0, that is for contexts 0 to 3. It follows active_map in the same cycle.
- R3: A cycle with cpu_map_we high, svc_req low and no abort condition loads cpu_map_wdata into active_map at the next clock edge.
- R4: The abort condition is instr_priv high while supervisor is 0. It makes abort high for exactly the next cycle. Each cycle of the condition gives one abort cycle, and abort is 0 in any cycle not preceded by the condition.
- R5: instr_priv while supervisor is 1 never raises abort.
- R6: In a cycle with the abort condition, the cpu_map_we write and the svc_req of that cycle are both discarded. active_map keeps its value and redirect_valid stays 0.
- R7: A svc_req without the abort condition sets active_map to 0 at the next edge. In that next cycle it also drives redirect_valid to 1 for one cycle, with redirect_addr equal to 0x0100. redirect_addr is 0 whenever redirect_valid is 0.
- R8: When svc_req and cpu_map_we are high in the same cycle, svc_req wins: active_map becomes 0 and the write data is dropped.
- R9: dma_map_we loads dma_map_wdata into dma_map at the next edge. dma_map changes only through that port, and that port never changes active_map.
- R10: A supervisor call issued from a supervisor context other than 0 also lands in context 0 with a redirect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_priv | input | 1 | A privileged instruction is issued this cycle |
| svc_req | input | 1 | A supervisor call is issued this cycle |
| cpu_map_we | input | 1 | Write strobe for the active map index |
| cpu_map_wdata | input | 3 | New active map index |
| dma_map_we | input | 1 | Write strobe for the DMA map index |
| dma_map_wdata | input | 3 | New DMA map index |
| active_map | output | 3 | Current processor map context |
| dma_map | output | 3 | Map context used for DMA |
| supervisor | output | 1 | 1 while the active context is 0 to 3 |
| abort | output | 1 | One-cycle pulse for a privileged instruction in user context |
| redirect_valid | output | 1 | One-cycle request to load the program counter |
| redirect_addr | output | 16 | Redirect target, 0x0100 while valid and 0 otherwise |

## Verification
All state and pulse outputs are registered. active_map, dma_map, abort, redirect_valid and redirect_addr reflect a stimulus one clock edge after the cycle that presents it. supervisor follows active_map in that same cycle, with no extra delay. The bench drives inputs on the falling edge. At the next falling edge it compares every output with a model that applies the R4/R6/R7/R8 priority. That way each result is sampled exactly one edge after its cause, and no check lands on an active edge. Directed steps cover abort while writes and calls are pending, call-versus-write collisions and calls from non-zero supervisor contexts. A seeded random run follows.

// File: rtl/map_ctx_pkg.sv
package map_ctx_pkg;

  // How the active index is updated on the coming edge
  typedef enum logic [1:0] {
    UPD_HOLD  = 2'd0,
    UPD_SVC   = 2'd1,
    UPD_WRITE = 2'd2
  } upd_sel_e;

endpackage

// File: rtl/ctx_idx_reg.sv
// Plain write-enabled index register (used for the DMA context)
module ctx_idx_reg #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] idx
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  idx <= '0;
    else if (we) idx <= wdata;
  end

  // R9
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> idx == $past(wdata));

  // R9
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(idx));

endmodule

// File: rtl/cpu_ctx_reg.sv
// Active processor context register, updated per the guard's selection
module cpu_ctx_reg
  import map_ctx_pkg::*;
#(
  parameter int          W       = 3,
  parameter logic [W-1:0] SVC_MAP = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  upd_sel_e     upd,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] idx
);

  logic [W-1:0] idx_nxt;

  always_comb begin
    unique case (upd)
      UPD_SVC:   idx_nxt = SVC_MAP;
      UPD_WRITE: idx_nxt = wdata;
      default:   idx_nxt = idx;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx <= '0;
    else        idx <= idx_nxt;
  end

  // R7
  svc_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd == UPD_SVC |=> idx == SVC_MAP);

  // R3
  wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd == UPD_WRITE |=> idx == $past(wdata));

  // R6
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd == UPD_HOLD |=> $stable(idx));

endmodule

// File: rtl/priv_guard.sv
// Privilege check, update priority, abort and redirect pulses
module priv_guard
  import map_ctx_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     supervisor,
  input  logic     instr_priv,
  input  logic     svc_req,
  input  logic     cpu_map_we,
  output upd_sel_e upd,
  output logic     abort,
  output logic     redirect_valid
);

  logic violation;

  assign violation = instr_priv & ~supervisor;

  // Priority: violation freezes everything, then call, then write
  always_comb begin
    if (violation)       upd = UPD_HOLD;
    else if (svc_req)    upd = UPD_SVC;
    else if (cpu_map_we) upd = UPD_WRITE;
    else                 upd = UPD_HOLD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort          <= 1'b0;
      redirect_valid <= 1'b0;
    end else begin
      abort          <= violation;
      redirect_valid <= svc_req & ~violation;
    end
  end

  // R4
  abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> $past(instr_priv && !supervisor));

  // R5
  sup_no_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_priv && supervisor) |=> !abort);

  // R6
  abort_no_redir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !redirect_valid);

endmodule

// File: rtl/map_ctx_ctrl.sv
module map_ctx_ctrl
  import map_ctx_pkg::*;
#(
  parameter int           MAP_W     = 3,
  parameter int           PC_W      = 16,
  parameter logic [MAP_W-1:0] SVC_MAP   = '0,
  parameter logic [PC_W-1:0]  SVC_ENTRY = 16'h0100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_priv,
  input  logic             svc_req,
  input  logic             cpu_map_we,
  input  logic [MAP_W-1:0] cpu_map_wdata,
  input  logic             dma_map_we,
  input  logic [MAP_W-1:0] dma_map_wdata,
  output logic [MAP_W-1:0] active_map,
  output logic [MAP_W-1:0] dma_map,
  output logic             supervisor,
  output logic             abort,
  output logic             redirect_valid,
  output logic [PC_W-1:0]  redirect_addr
);

  // User space is the upper half of the index range
  localparam int USER_BIT = MAP_W - 1;

  upd_sel_e upd;

  assign supervisor    = ~active_map[USER_BIT];
  assign redirect_addr = redirect_valid ? SVC_ENTRY : '0;

  priv_guard u_guard (
    .clk            (clk),
    .rst_n          (rst_n),
    .supervisor     (supervisor),
    .instr_priv     (instr_priv),
    .svc_req        (svc_req),
    .cpu_map_we     (cpu_map_we),
    .upd            (upd),
    .abort          (abort),
    .redirect_valid (redirect_valid)
  );

  cpu_ctx_reg #(.W(MAP_W), .SVC_MAP(SVC_MAP)) u_cpu (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (upd),
    .wdata (cpu_map_wdata),
    .idx   (active_map)
  );

  ctx_idx_reg #(.W(MAP_W)) u_dma (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (dma_map_we),
    .wdata (dma_map_wdata),
    .idx   (dma_map)
  );

  // R7
  redir_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> (active_map == SVC_MAP && redirect_addr == SVC_ENTRY));

  // R6
  abort_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> active_map == $past(active_map));

  // R9
  dma_isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(dma_map_we) |-> $stable(dma_map));

endmodule

// File: tb/tb_map_ctx_ctrl.sv
`timescale 1ns/1ps
module tb_map_ctx_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       instr_priv, svc_req, cpu_map_we, dma_map_we;
  logic [2:0] cpu_map_wdata, dma_map_wdata;
  logic [2:0] active_map, dma_map;
  logic       supervisor, abort, redirect_valid;
  logic [15:0] redirect_addr;

  int errors = 0;
  int checks = 0;

  logic [2:0] m_act = 3'd0;
  logic [2:0] m_dma = 3'd0;

  always #4 clk = ~clk;

  map_ctx_ctrl dut (
    .clk(clk), .rst_n(rst_n), .instr_priv(instr_priv), .svc_req(svc_req),
    .cpu_map_we(cpu_map_we), .cpu_map_wdata(cpu_map_wdata),
    .dma_map_we(dma_map_we), .dma_map_wdata(dma_map_wdata),
    .active_map(active_map), .dma_map(dma_map), .supervisor(supervisor),
    .abort(abort), .redirect_valid(redirect_valid), .redirect_addr(redirect_addr)
  );

  function automatic logic f_abort(logic [2:0] act, logic priv);
    return priv && act[2];
  endfunction

  function automatic logic [2:0] f_next(logic [2:0] act, logic priv, logic svc,
                                         logic we, logic [2:0] wd);
    if (f_abort(act, priv)) return act;
    if (svc) return 3'd0;
    if (we) return wd;
    return act;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive one cycle at a falling edge, check at the next falling edge
  task automatic step(logic priv, logic svc, logic we, logic [2:0] wd,
                      logic dwe, logic [2:0] dwd);
    logic e_abort, e_redir;
    logic [2:0] e_act, e_dma;
    string tag_act;
    instr_priv = priv; svc_req = svc; cpu_map_we = we; cpu_map_wdata = wd;
    dma_map_we = dwe; dma_map_wdata = dwd;
    e_abort = f_abort(m_act, priv);
    e_redir = svc && !e_abort;
    e_act   = f_next(m_act, priv, svc, we, wd);
    e_dma   = dwe ? dwd : m_dma;
    if (e_abort) tag_act = "R6";
    else if (svc && we) tag_act = "R8";
    else if (svc && m_act != 3'd0) tag_act = "R10";
    else if (svc) tag_act = "R7";
    else tag_act = "R3";
    @(negedge clk);
    m_act = e_act; m_dma = e_dma;
    chk(tag_act, "active_map", int'(active_map), int'(e_act));
    chk("R2", "supervisor", int'(supervisor), int'(!e_act[2]));
    chk(m_act[2] || !priv ? "R4" : "R5", "abort", int'(abort), int'(e_abort));
    chk("R7", "redirect_valid", int'(redirect_valid), int'(e_redir));
    chk("R7", "redirect_addr", int'(redirect_addr), e_redir ? 16'h0100 : 0);
    chk("R9", "dma_map", int'(dma_map), int'(e_dma));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0; instr_priv = 0; svc_req = 0; cpu_map_we = 0;
    cpu_map_wdata = 0; dma_map_we = 0; dma_map_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1", "active_map", int'(active_map), 0);
    chk("R1", "dma_map", int'(dma_map), 0);
    chk("R1", "supervisor", int'(supervisor), 1);
    chk("R1", "abort", int'(abort), 0);
    chk("R1", "redirect_valid", int'(redirect_valid), 0);

    // R5 privileged in supervisor context
    step(1, 0, 0, 3'd0, 0, 3'd0);
    // R3 move to user context 5
    step(0, 0, 1, 3'd5, 0, 3'd0);
    // R4 privileged in user context, then pulse must drop
    step(1, 0, 0, 3'd0, 0, 3'd0);
    step(0, 0, 0, 3'd0, 0, 3'd0);
    // R6 abort with pending write and call
    step(1, 1, 1, 3'd1, 0, 3'd0);
    step(1, 0, 1, 3'd2, 1, 3'd6);
    // R7 call from user context
    step(0, 1, 0, 3'd0, 0, 3'd0);
    // R8 call and write together
    step(0, 0, 1, 3'd7, 0, 3'd0);
    step(0, 1, 1, 3'd6, 0, 3'd0);
    // R10 call from supervisor context 2
    step(0, 0, 1, 3'd2, 0, 3'd0);
    step(0, 1, 0, 3'd0, 0, 3'd0);
    // R9 DMA write alongside processor activity
    step(0, 1, 0, 3'd0, 1, 3'd3);
    step(0, 0, 1, 3'd4, 1, 3'd7);

    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 4) == 0, ($urandom % 8) == 0, ($urandom % 3) == 0,
           3'($urandom), ($urandom % 4) == 0, 3'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule